// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

A small register-bus slave that owns a row of general-purpose output pins and samples a row of general-purpose input pins. A single word-wide data register drives the outputs. A read of the same offset returns the input pins after they pass through a two-flop synchronizer. The register width is a build parameter of 8, 16, 32 or 64 bits, and the pin count equals that width.

A build option adds a pair of write-only strobe registers. Writing ones to the first sets the matching data bits, and writing ones to the second clears them. Bits written as zero keep their state. Software can therefore change single pins without a read-modify-write sequence. A second build option reverses the pin-to-bit ordering, so that pin n sits on register bit (REG_W-1-n). The block has no direction, drive-mode or pull control, so pins need no setup before use.

The bus is a plain word-addressed interface: address, write enable, write data, and a read data return that depends only on the current address, with no added cycle. Only one register is accessed per cycle.

Top module: `gpio_regbank`

## Requirements
- R1: While reset is asserted and after reset, until the first write, the data register and every output pin are 0.
- R2: A write (bus_we=1) at word offset 0 loads the data register, and the output pins show the written value from the clock edge that takes the write.
- R3: With the strobe option enabled (HAS_SETCLR=1), a write at offset 1 sets each data bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. It takes effect at the same clock edge.
- R4: With the strobe option enabled, a write at offset 2 clears each data bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. It takes effect at the same clock edge.
- R5: A read at offset 1, 2 or 3 returns 0. A write at offset 3 changes no output pin.
- R6: A read at offset 0 returns the input pins as sampled two clock edges earlier, through a two-flop synchronizer.
- R7: With REVERSE_ORDER=1, pin n maps to register bit (REG_W-1-n) for both the outputs and the read-back. With REVERSE_ORDER=0, pin n maps to bit n.
- R8: With the strobe option disabled (HAS_SETCLR=0), writes at offsets 1 and 2 change no output pin.
- R9: REG_W must be 8, 16, 32 or 64, and both pin vectors are REG_W bits wide. Any other width stops elaboration.
- R10: A cycle with bus_we=0 leaves the output pins unchanged, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the accessed register |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for the current address |
| gpio_in | input | REG_W | Input pin vector (asynchronous) |
| gpio_out | output | REG_W | Output pin vector |

## Verification
The bench builds two 8-bit instances that share one bus. The first has the strobe registers and reversed ordering. The second is the minimal build, with natural ordering and no strobe registers. With 8 bits, every data value and every set or clear mask can be swept over a spread of starting values. Every input pattern is also swept through the synchronizer, in both orderings. The shared bus shows directly that a strobe write which changes the full build leaves the minimal build untouched.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

   // Word offsets of the register bank; the order fixes the override priority.
   typedef enum logic [1:0] {
      OFS_DATA  = 2'd0,
      OFS_SET   = 2'd1,
      OFS_CLEAR = 2'd2,
      OFS_NONE  = 2'd3
   } gpio_ofs_e;

   localparam int unsigned OFS_BITS = 2;

   function automatic bit legal_width(input int unsigned w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[LAST];

endmodule

// File: rtl/gpio_bitmap.sv
module gpio_bitmap #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          REVERSE = 1'b0
) (
   input  logic [WIDTH-1:0] src_i,
   output logic [WIDTH-1:0] dst_o
);

   localparam int unsigned TOP = WIDTH - 1;

   if (REVERSE) begin : g_rev
      for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
         assign dst_o[i] = src_i[TOP-i];
      end
   end else begin : g_fwd
      assign dst_o = src_i;
   end

endmodule

// File: rtl/gpio_datareg.sv
module gpio_datareg #(
   parameter int unsigned WIDTH      = 8,
   parameter bit          HAS_SETCLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data_i,
   input  logic             wr_set_i,
   input  logic             wr_clr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] data_o
);

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] data_d;

   if (HAS_SETCLR) begin : g_strobes
      // Later offset wins when more than one strobe is seen in a cycle.
      always_comb begin
         data_d = data_q;
         if (wr_data_i) data_d = wdata_i;
         if (wr_set_i)  data_d = data_q | wdata_i;
         if (wr_clr_i)  data_d = data_q & ~wdata_i;
      end
   end else begin : g_plain
      logic unused_strobes;
      assign unused_strobes = wr_set_i ^ wr_clr_i;
      always_comb begin
         data_d = data_q;
         if (wr_data_i) data_d = wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= data_d;
   end

   assign data_o = data_q;

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned REG_W         = 8,
   parameter int unsigned ADDR_W        = 2,
   parameter bit          HAS_SETCLR    = 1'b1,
   parameter bit          REVERSE_ORDER = 1'b0,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [REG_W-1:0]  gpio_in,
   output logic [REG_W-1:0]  gpio_out
);

   localparam int unsigned HI_BITS = ADDR_W - OFS_BITS;

   // R9: only the four register widths are legal
   if (!legal_width(REG_W)) begin : g_bad_width
      $error("gpio_regbank: REG_W must be 8, 16, 32 or 64");
   end
   if (ADDR_W < OFS_BITS) begin : g_bad_addr
      $error("gpio_regbank: ADDR_W too small for the register bank");
   end

   // Address decode: upper address bits must be zero to hit the bank.
   logic      hit;
   gpio_ofs_e ofs;

   if (HI_BITS > 0) begin : g_hi
      assign hit = (bus_addr[ADDR_W-1:OFS_BITS] == '0);
   end else begin : g_nohi
      assign hit = 1'b1;
   end
   assign ofs = gpio_ofs_e'(bus_addr[OFS_BITS-1:0]);

   logic wr_data, wr_set, wr_clr;
   assign wr_data = bus_we && hit && (ofs == OFS_DATA);
   assign wr_set  = bus_we && hit && (ofs == OFS_SET);
   assign wr_clr  = bus_we && hit && (ofs == OFS_CLEAR);

   logic [REG_W-1:0] data_reg;

   gpio_datareg #(
      .WIDTH      (REG_W),
      .HAS_SETCLR (HAS_SETCLR)
   ) u_datareg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data_i (wr_data),
      .wr_set_i  (wr_set),
      .wr_clr_i  (wr_clr),
      .wdata_i   (bus_wdata),
      .data_o    (data_reg)
   );

   // Register bits to pins (R7)
   gpio_bitmap #(
      .WIDTH   (REG_W),
      .REVERSE (REVERSE_ORDER)
   ) u_map_out (
      .src_i (data_reg),
      .dst_o (gpio_out)
   );

   // Pins to synchronizer to register bits (R6, R7)
   logic [REG_W-1:0] pins_sync;
   logic [REG_W-1:0] pins_bits;

   gpio_sync #(
      .WIDTH  (REG_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (gpio_in),
      .sync_o  (pins_sync)
   );

   gpio_bitmap #(
      .WIDTH   (REG_W),
      .REVERSE (REVERSE_ORDER)
   ) u_map_in (
      .src_i (pins_sync),
      .dst_o (pins_bits)
   );

   // Read mux: strobe registers and the spare offset read as zero (R5)
   always_comb begin
      bus_rdata = '0;
      if (hit && (ofs == OFS_DATA)) bus_rdata = pins_bits;
   end

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int unsigned REG_W         = 8,
   parameter int unsigned ADDR_W        = 2,
   parameter bit          HAS_SETCLR    = 1'b1,
   parameter bit          REVERSE_ORDER = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [REG_W-1:0]  gpio_in,
   input logic [REG_W-1:0]  gpio_out
);

   function automatic logic [REG_W-1:0] to_pins(input logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      for (int i = 0; i < int'(REG_W); i++)
         r[i] = REVERSE_ORDER ? v[REG_W-1-i] : v[i];
      return r;
   endfunction

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   logic a_data, a_set, a_clr, a_other;
   assign a_data  = (bus_addr == ADDR_W'(0));
   assign a_set   = (bus_addr == ADDR_W'(1));
   assign a_clr   = (bus_addr == ADDR_W'(2));
   assign a_other = !a_data;

   AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && a_data |=> gpio_out == to_pins($past(bus_wdata))); // R2

   AST_SET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_SETCLR && bus_we && a_set |=>
         gpio_out == ($past(gpio_out) | to_pins($past(bus_wdata)))); // R3

   AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_SETCLR && bus_we && a_clr |=>
         gpio_out == ($past(gpio_out) & ~to_pins($past(bus_wdata)))); // R4

   AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      a_other |-> bus_rdata == '0); // R5

   AST_SYNC_READ: assert property (@(posedge clk) disable iff (!rst_n)
      a_data && (age_q >= 2'd2) |-> to_pins(bus_rdata) == $past(gpio_in, 2)); // R6

   AST_NO_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_SETCLR && bus_we && a_other |=> $stable(gpio_out)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(gpio_out)); // R10

endmodule

bind gpio_regbank gpio_regbank_chk #(
   .REG_W         (REG_W),
   .ADDR_W        (ADDR_W),
   .HAS_SETCLR    (HAS_SETCLR),
   .REVERSE_ORDER (REVERSE_ORDER)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .gpio_in   (gpio_in),
   .gpio_out  (gpio_out)
);

// File: tb/gpio_regbank_bench.sv
module gpio_regbank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int WDOG_LIMIT = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   addr = '0;
   logic         we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] pins_in = '0;
   logic [W-1:0] rd_full, rd_min, out_full, out_min;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Full build: strobes and reversed ordering
   gpio_regbank #(.REG_W(W), .ADDR_W(2), .HAS_SETCLR(1'b1), .REVERSE_ORDER(1'b1)) u_gpio_regbank (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_full), .gpio_in(pins_in), .gpio_out(out_full));

   // Minimal build: data register only, natural ordering
   gpio_regbank #(.REG_W(W), .ADDR_W(2), .HAS_SETCLR(1'b0), .REVERSE_ORDER(1'b0)) u_gpio_regbank_min (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_min), .gpio_in(pins_in), .gpio_out(out_min));

   function automatic logic [W-1:0] rev(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   // Write one register; returns at the falling edge after the taking edge.
   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG_LIMIT && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG_LIMIT);
         summary();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] base;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset full", out_full, '0);
      check("R1 reset min", out_min, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset full", out_full, '0);
      check("R1 after reset min", out_min, '0);

      // R9: pin vector width equals register width
      check("R9 width", W'($bits(out_full)), W'(W));
      check("R9 width in", W'($bits(u_gpio_regbank.gpio_in)), W'(W));

      // R2, R7: every data value
      for (int v = 0; v < (1 << W); v++) begin
         bus_write(2'd0, W'(v));
         check("R2 R7 data write full", out_full, rev(W'(v)));
         check("R2 data write min", out_min, W'(v));
      end

      // R10: no write enable means no change
      bus_write(2'd0, 8'h5A);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         addr = 2'(a); wdata = 8'hFF; we = 1'b0;
         @(posedge clk);
         @(negedge clk);
         check("R10 idle full", out_full, rev(8'h5A));
         check("R10 idle min", out_min, 8'h5A);
      end

      // R5: write to spare offset 3 is ignored
      bus_write(2'd3, 8'hFF);
      check("R5 spare write full", out_full, rev(8'h5A));
      check("R5 spare write min", out_min, 8'h5A);
      bus_write(2'd3, 8'h00);
      check("R5 spare write zero full", out_full, rev(8'h5A));

      // R3, R4, R8: set and clear strobes over all masks
      for (int s = 0; s < 16; s++) begin
         base = W'(s * 17);
         for (int m = 0; m < (1 << W); m++) begin
            bus_write(2'd0, base);
            bus_write(2'd1, W'(m));
            check("R3 set full", out_full, rev(base | W'(m)));
            check("R8 set ignored min", out_min, base);
            bus_write(2'd0, base);
            bus_write(2'd2, W'(m));
            check("R4 clear full", out_full, rev(base & ~W'(m)));
            check("R8 clear ignored min", out_min, base);
         end
      end

      // R6, R7: input read-back through the synchronizer
      for (int v = 0; v < (1 << W); v++) begin
         @(negedge clk);
         addr = 2'd0; pins_in = W'(v);
         @(posedge clk);
         @(posedge clk);
         @(negedge clk);
         check("R6 R7 read full", rd_full, rev(W'(v)));
         check("R6 read min", rd_min, W'(v));
      end

      // R6: value not visible after only one edge
      @(negedge clk);
      pins_in = 8'h3C;
      @(posedge clk);
      @(negedge clk);
      check("R6 latency min", rd_min, 8'hFF);
      @(posedge clk);
      @(negedge clk);
      check("R6 latency settled min", rd_min, 8'h3C);

      // R5: strobe and spare offsets read zero
      pins_in = 8'hFF;
      repeat (3) @(negedge clk);
      for (int a = 1; a < 4; a++) begin
         addr = 2'(a);
         #1;
         check("R5 read zero full", rd_full, '0);
         check("R5 read zero min", rd_min, '0);
         @(negedge clk);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule